// File: doc/BRIEF.md
# Pixel Event Capture Sequencer

This block is the digital control for one pixel of a charge readout channel during a bunch train. It runs on a fast system clock and receives a one-cycle bunch-crossing strobe, train start and train end pulses, and the outputs of two discriminators. The event discriminator reports that the pixel has fired. The range discriminator reports that the signal is large enough to need the low-gain path. The block counts crossings over the train. On each accepted hit it records the crossing number, the gain range and a running event number in the next free slot of a small store. The store keeps its contents until the next train begins.

Each accepted hit starts a timed switch sequence. The track control closes after a settling delay and opens again at the hold point. After the hold, a reset is issued on the next bunch crossing, and the channel re-arms once the recovery time has passed. The high-gain reset normally fires on every crossing. It is held off while a hit is being processed. The low-gain reset fires only at startup and once after each hit. All delays are counted in system-clock cycles and are set by parameters. The defaults assume a 100 MHz clock.

Top module: `pix_evt_seq`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, lg_rst_o is high. trk_o, hg_rst_o, busy_o and ovf_o are low, no slot is valid, and bx_count_o is 0.
- R2: A train_start pulse clears bx_count_o to 0 and arms the block. While armed, each bx_strobe cycle adds 1 at the next edge. The count stops at 4095 and never wraps.
- R3: A rising edge of evt_disc is accepted when the block is armed, idle and has a free slot, and train_start is low in that cycle. Slots fill in order from 0 to 3. The filled slot becomes valid and stores the bx_count_o value seen in the trigger cycle. Slot i occupies bits [12*i+11:12*i] of slot_ts_o and bits [5*i+4:5*i] of slot_ev_o.
- R4: Every rising edge of evt_disc while armed raises a 5-bit event number by 1, stopping at 31. This includes edges that are ignored. An accepted hit stores the number that includes its own edge.
- R5: A slot's range bit (slot_rng_o[i]) is set if rng_disc is high in the trigger cycle or in any of the RNG_WIN cycles after it. Later range pulses do not change it.
- R6: trk_o goes high TRK_DLY edges after the trigger edge and low HOLD_DLY edges after it.
- R7: After the hold, the first bx_strobe produces a single one-cycle pulse on both hg_rst_o and lg_rst_o, one cycle later.
- R8: While idle, every bx_strobe is followed one cycle later by a hg_rst_o pulse. While a hit is in progress, hg_rst_o stays low apart from the R7 pulse. lg_rst_o fires only as stated in R1 and R7.
- R9: busy_o is high from the trigger edge until the later of two points: READY_DLY edges after the trigger, and one edge after the R7 reset. A new trigger is accepted once it is low.
- R10: A rising edge of evt_disc while busy_o is high fills no slot and does not change the track timing.
- R11: A trigger that finds all slots full is dropped and sets ovf_o. ovf_o stays set until train_start, which also clears all slots.
- R12: After a train_end pulse, triggers are ignored, the slots hold their contents and bx_count_o holds its value until the next train_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bx_strobe | input | 1 | One-cycle pulse per bunch crossing |
| train_start | input | 1 | Starts a train: clears the counter, slots and overflow, then arms |
| train_end | input | 1 | Ends a train: disarms capture |
| evt_disc | input | 1 | Event discriminator output |
| rng_disc | input | 1 | Range discriminator output |
| trk_o | output | 1 | Track switch control |
| hg_rst_o | output | 1 | High-gain reset switch |
| lg_rst_o | output | 1 | Low-gain reset switch |
| busy_o | output | 1 | Hit sequence in progress |
| ovf_o | output | 1 | Sticky slot overflow |
| bx_count_o | output | 12 | Crossing counter |
| slot_valid_o | output | 4 | Per-slot valid bits |
| slot_rng_o | output | 4 | Per-slot range bits |
| slot_ts_o | output | 48 | Per-slot crossing stamps, 12 bits each |
| slot_ev_o | output | 20 | Per-slot event numbers, 5 bits each |

## Verification
A wrong sequencer state shows at the ports within one crossing period. A stuck or restarted timer moves the falling edge of trk_o or the end of busy_o, and a wrong state lets hg_rst_o pulse in the middle of a hit or keeps the R7 reset from appearing. A wrong fill pointer or event counter shows as soon as the slot is written: the stamp, the event number or the valid pattern is wrong. A saturation or freeze fault in the crossing counter appears on bx_count_o in the cycle after the offending strobe.

// File: rtl/pix_evt_seq.sv
module pix_evt_seq #(
  parameter int NSLOT     = 4,
  parameter int TS_W      = 12,
  parameter int EC_W      = 5,
  parameter int TRK_DLY   = 15,
  parameter int HOLD_DLY  = 100,
  parameter int READY_DLY = 120,
  parameter int RNG_WIN   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bx_strobe,
  input  logic                  train_start,
  input  logic                  train_end,
  input  logic                  evt_disc,
  input  logic                  rng_disc,
  output logic                  trk_o,
  output logic                  hg_rst_o,
  output logic                  lg_rst_o,
  output logic                  busy_o,
  output logic                  ovf_o,
  output logic [TS_W-1:0]       bx_count_o,
  output logic [NSLOT-1:0]      slot_valid_o,
  output logic [NSLOT-1:0]      slot_rng_o,
  output logic [NSLOT*TS_W-1:0] slot_ts_o,
  output logic [NSLOT*EC_W-1:0] slot_ev_o
);

  localparam int PTR_W = $clog2(NSLOT + 1);
  localparam int TMR_W = $clog2(READY_DLY + 2);
  localparam logic [PTR_W-1:0] FULL   = PTR_W'(NSLOT);
  localparam logic [TMR_W-1:0] T_TRK  = TMR_W'(TRK_DLY);
  localparam logic [TMR_W-1:0] T_HOLD = TMR_W'(HOLD_DLY - 1);
  localparam logic [TMR_W-1:0] T_RDY  = TMR_W'(READY_DLY - 1);
  localparam logic [TMR_W-1:0] T_RNG  = TMR_W'(RNG_WIN);

  typedef enum logic [1:0] {S_IDLE, S_TRACK, S_WAIT, S_RECOV} st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [PTR_W-1:0] fill, cur;
  logic [TS_W-1:0]  bx_cnt;
  logic [EC_W-1:0]  evcnt, ev_next;
  logic             evt_q, armed, ovf_q, hg_rst_q, lg_rst_q;
  logic             rise, accept, drop_full, rng_open;

  assign rise      = evt_disc & ~evt_q;
  assign accept    = rise & armed & ~train_start & (st == S_IDLE) & (fill != FULL);
  assign drop_full = rise & armed & ~train_start & (st == S_IDLE) & (fill == FULL);
  assign rng_open  = (st == S_TRACK) && (tmr < T_RNG);
  assign ev_next   = (evcnt == '1) ? evcnt : evcnt + 1'b1;

  assign trk_o      = (st == S_TRACK) && (tmr >= T_TRK);
  assign busy_o     = (st != S_IDLE);
  assign hg_rst_o   = hg_rst_q;
  assign lg_rst_o   = lg_rst_q;
  assign ovf_o      = ovf_q;
  assign bx_count_o = bx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      armed  <= 1'b0;
      bx_cnt <= '0;
      evcnt  <= '0;
      fill   <= '0;
      cur    <= '0;
      ovf_q  <= 1'b0;
    end else begin
      evt_q <= evt_disc;
      if (train_start) begin
        armed  <= 1'b1;
        bx_cnt <= '0;
        evcnt  <= '0;
        fill   <= '0;
        ovf_q  <= 1'b0;
      end else begin
        if (train_end) armed <= 1'b0;
        if (armed && bx_strobe && bx_cnt != '1) bx_cnt <= bx_cnt + 1'b1;
        if (armed && rise) evcnt <= ev_next;
        if (accept) begin
          fill <= fill + 1'b1;
          cur  <= fill;
        end
        if (drop_full) ovf_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      hg_rst_q <= 1'b0;
      lg_rst_q <= 1'b1;
    end else begin
      hg_rst_q <= bx_strobe & ((st == S_IDLE) | (st == S_WAIT));
      lg_rst_q <= bx_strobe & (st == S_WAIT);
      if (st == S_IDLE) tmr <= '0;
      else if (tmr != '1) tmr <= tmr + 1'b1;
      case (st)
        S_IDLE:  if (accept) st <= S_TRACK;
        S_TRACK: if (tmr == T_HOLD) st <= S_WAIT;
        S_WAIT:  if (bx_strobe) st <= S_RECOV;
        default: if (tmr >= T_RDY) st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic            vld, rng;
    logic [TS_W-1:0] ts;
    logic [EC_W-1:0] ev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= 1'b0;
        rng <= 1'b0;
        ts  <= '0;
        ev  <= '0;
      end else if (train_start) begin
        vld <= 1'b0;
        rng <= 1'b0;
        ts  <= '0;
        ev  <= '0;
      end else if (accept && fill == PTR_W'(i)) begin
        vld <= 1'b1;
        rng <= rng_disc;
        ts  <= bx_cnt;
        ev  <= ev_next;
      end else if (rng_open && cur == PTR_W'(i) && rng_disc) begin
        rng <= 1'b1;
      end
    end
    assign slot_valid_o[i]            = vld;
    assign slot_rng_o[i]              = rng;
    assign slot_ts_o[i*TS_W +: TS_W]  = ts;
    assign slot_ev_o[i*EC_W +: EC_W]  = ev;
  end

  // R6: track only inside a running hit
  a_r6_track_in_hit: assert property (@(posedge clk) disable iff (!rst_n)
    trk_o |-> busy_o);

  // R8: no high-gain reset in the middle of tracking
  a_r8_no_hg_in_track: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRACK && tmr != '0) |-> !hg_rst_q);

  // R7: low-gain reset only rises as recovery begins
  a_r7_lg_on_recover: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lg_rst_q) |-> st == S_RECOV);

  // R11: overflow is sticky
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !train_start) |=> ovf_q);

  // R2: the crossing counter stops at its maximum
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bx_cnt == '1 && !train_start) |=> bx_cnt == '1);

  // R3: slots are only added within a train
  a_r3_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !train_start |=> fill >= $past(fill));

  // R10: tracking timer is never restarted
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRACK) |=> tmr == $past(tmr) + TMR_W'(1));

endmodule

// File: tb/pix_evt_seq_tb.sv
module pix_evt_seq_tb_top;
  localparam int TRK = 15, HOLD = 100, RDY = 120, RWIN = 10, BXP = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bx_auto = 1'b0, bx_man = 1'b0, bx_en = 1'b0;
  logic train_start = 1'b0, train_end = 1'b0, evt = 1'b0, rng = 1'b0;
  logic bx_strobe;
  logic trk, hg, lg, busy, ovf;
  logic [11:0] bxc;
  logic [3:0]  vld, srng;
  logic [47:0] sts;
  logic [19:0] sev;
  int nchk = 0, nerr = 0, bx_div = 0, nvalid = 0, exp_ev = 0;

  assign bx_strobe = bx_auto | bx_man;
  always #10 clk = ~clk;

  pix_evt_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bx_strobe(bx_strobe), .train_start(train_start),
    .train_end(train_end), .evt_disc(evt), .rng_disc(rng), .trk_o(trk),
    .hg_rst_o(hg), .lg_rst_o(lg), .busy_o(busy), .ovf_o(ovf), .bx_count_o(bxc),
    .slot_valid_o(vld), .slot_rng_o(srng), .slot_ts_o(sts), .slot_ev_o(sev));

  always @(negedge clk) begin
    if (bx_en) begin
      bx_div  = (bx_div == BXP - 1) ? 0 : bx_div + 1;
      bx_auto = (bx_div == 0);
    end else bx_auto = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int sat31(input int v);
    return (v > 31) ? 31 : v;
  endfunction

  task automatic t_reset;
    step(3);
    chk(lg == 1'b1, "R1 lg_rst during reset", lg, 1);
    chk({trk, hg, busy, ovf} == 4'b0, "R1 controls low in reset", {trk, hg, busy, ovf}, 0);
    chk(vld == 4'h0 && bxc == 12'd0, "R1 slots and counter clear", vld, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(lg == 1'b1, "R1 lg_rst before first edge", lg, 1);
    step(1);
    chk(lg == 1'b0, "R1 lg_rst drops after first edge", lg, 0);
  endtask

  task automatic t_train_start;
    @(negedge clk); train_start = 1'b1;
    @(negedge clk); train_start = 1'b0; #1;
    nvalid = 0; exp_ev = 0;
  endtask

  task automatic t_count;
    t_train_start();
    chk(bxc == 12'd0, "R2 cleared by train_start", bxc, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); bx_man = 1'b1;
      @(negedge clk); bx_man = 1'b0;
      step(2);
    end
    chk(bxc == 12'd5, "R2 counts strobes", bxc, 5);
  endtask

  task automatic t_idle_hg;
    int bad = 0, lgbad = 0;
    bit prev = 1'b0;
    bx_en = 1'b1;
    for (int k = 0; k < 100; k++) begin
      step(1);
      if (k > 0 && hg !== prev) bad++;
      if (lg !== 1'b0) lgbad++;
      prev = bx_strobe;
    end
    chk(bad == 0, "R8 idle hg_rst follows strobe", bad, 0);
    chk(lgbad == 0, "R8 no lg_rst while idle", lgbad, 0);
  endtask

  task automatic t_seq(input int rng_at, input int retrig_at, input string tag);
    int slot = nvalid, ts_exp, ev_at, s = 1, prev, p = -1;
    int trk_bad = 0, rst_bad = 0, busy_bad = 0;
    bit bx_prev = 1'b0, hg_e, lg_e;
    bit rng_exp = (rng_at == -2) || (rng_at >= 0 && rng_at < RWIN);
    @(negedge clk); #1;
    ts_exp = bxc;
    evt = 1'b1;
    if (rng_at == -2) rng = 1'b1;
    exp_ev = sat31(exp_ev + 1); ev_at = exp_ev;
    for (int k = 0; k < 160; k++) begin
      step(1);
      prev = s;
      if (k == 0) s = 1;
      else if (prev == 1 && k == HOLD) s = 2;
      else if (prev == 2 && bx_prev) begin s = 3; p = k; end
      else if (prev == 3 && k >= RDY) s = 0;
      hg_e = bx_prev && (prev == 2 || prev == 0);
      lg_e = bx_prev && prev == 2;
      if (trk !== (s == 1 && k >= TRK)) trk_bad++;
      if (busy !== (s != 0)) busy_bad++;
      if (k > 0 && (hg !== hg_e || lg !== lg_e)) rst_bad++;
      bx_prev = bx_strobe;
      if (k == 0) rng = 1'b0;
      if (k == 2) evt = 1'b0;
      if (rng_at >= 0 && k == rng_at) rng = 1'b1;
      if (rng_at >= 0 && k == rng_at + 1) rng = 1'b0;
      if (k == retrig_at) begin evt = 1'b1; exp_ev = sat31(exp_ev + 1); end
      if (k == retrig_at + 2) evt = 1'b0;
    end
    chk(trk_bad == 0, {"R6 track window ", tag}, trk_bad, 0);
    chk(rst_bad == 0, {"R7 R8 reset pulses ", tag}, rst_bad, 0);
    chk(p > 0, {"R7 post-hold reset seen ", tag}, p, 1);
    chk(busy_bad == 0, {"R9 busy span ", tag}, busy_bad, 0);
    chk(vld[slot] == 1'b1, {"R3 slot valid ", tag}, vld[slot], 1);
    chk(sts[slot*12 +: 12] == ts_exp, {"R3 stamp ", tag}, sts[slot*12 +: 12], ts_exp);
    chk(sev[slot*5 +: 5] == ev_at, {"R4 event number ", tag}, sev[slot*5 +: 5], ev_at);
    chk(srng[slot] == rng_exp, {"R5 range bit ", tag}, srng[slot], rng_exp);
    if (retrig_at >= 0 && slot < 3)
      chk(vld[slot+1] == 1'b0, {"R10 retrigger ignored ", tag}, vld[slot+1], 0);
    nvalid++;
  endtask

  task automatic t_overflow;
    int bad = 0;
    logic [47:0] ts_keep = sts;
    @(negedge clk); evt = 1'b1; exp_ev = sat31(exp_ev + 1);
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (busy !== 1'b0 || trk !== 1'b0) bad++;
      if (k == 2) evt = 1'b0;
    end
    chk(ovf == 1'b1, "R11 overflow set", ovf, 1);
    chk(bad == 0, "R11 dropped hit starts no sequence", bad, 0);
    chk(vld == 4'hF && sts == ts_keep, "R11 slots unchanged", vld, 15);
    step(50);
    chk(ovf == 1'b1, "R11 overflow sticky", ovf, 1);
    t_train_start();
    chk(ovf == 1'b0 && vld == 4'h0, "R11 cleared by train_start", {ovf, vld}, 0);
  endtask

  task automatic t_end;
    int bad = 0;
    logic [11:0] frozen;
    step(70);
    @(negedge clk); train_end = 1'b1;
    @(negedge clk); train_end = 1'b0; #1;
    frozen = bxc;
    evt = 1'b1;
    for (int k = 0; k < 100; k++) begin
      step(1);
      if (busy !== 1'b0) bad++;
      if (k == 3) evt = 1'b0;
    end
    chk(bxc == frozen, "R12 counter frozen", bxc, frozen);
    chk(vld == 4'h0 && bad == 0, "R12 no capture after train_end", vld, 0);
  endtask

  task automatic t_saturate;
    bx_en = 1'b0;
    t_train_start();
    @(negedge clk); bx_man = 1'b1;
    repeat (4100) @(negedge clk);
    bx_man = 1'b0; #1;
    chk(bxc == 12'd4095, "R2 counter saturates", bxc, 4095);
  endtask

  initial begin
    t_reset();
    t_count();
    t_idle_hg();
    t_seq(-1, -1, "slot0");
    t_seq(-2, -1, "slot1");
    t_seq(RWIN - 1, 40, "slot2");
    t_seq(RWIN, -1, "slot3");
    t_overflow();
    t_end();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule